// File: doc/BRIEF.md
# SDIO Card Identification Controller

This block is the card-side controller that takes an SDIO card from power-up through bus identification and address assignment. It sees commands that an upstream parser has already decoded, as an index, a 32-bit argument and a one-cycle valid strobe. From these it keeps the card's life-cycle state and its current relative card address (RCA). It answers the operating-condition query, the identity request, the address assignment and the select command with a parsed response that a downstream framer turns into bits on the line.

When the host's voltage window does not overlap the card's supported range, the card retires for good into an inactive state. In that state nothing except the synchronous reset brings it back. The host may assign an address more than once, and the last assignment is the one kept. A card whose address is zero can never be selected. Every accepted command produces its response on the cycle after the strobe. Commands that are not legal in the current state change nothing.

Top module: `sdio_card_ident`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cardState` = 0 (idle), `rca` = 0, `selected` = 0 and `respValid` = 0.
- R2: Index 5 in idle, where argument bits [23:0] are nonzero and overlap the supported mask, moves the state to 1 (ready). It also answers with kind 1 and data {8'h00, mask}.
- R3: Index 5 in idle, where argument bits [23:0] are nonzero and share no bit with the mask, still answers with kind 1. It moves the state to 4 (inactive). From then on every command, index 0 included, gives no response and changes nothing until `rst`.
- R4: Index 5 in idle with argument bits [23:0] equal to zero answers with kind 1 and the mask, and the state stays idle.
- R5: Index 2 in ready moves the state to 2 (identification) and answers with kind 2 and the parameter card tag.
- R6: Index 3 in ready or identification moves the state to 3 (standby), loads `rca` from argument bits [31:16], and answers with kind 3 and data {new RCA, 16'h0000}.
- R7: Index 3 in standby replaces `rca` with the new argument value, so the last assignment is in effect. It answers as in R6 and clears `selected`.
- R8: Index 7 in standby whose argument bits [31:16] equal a nonzero `rca` sets `selected` and answers with kind 3 and {rca, 16'h0000}. Any other index-7 argument clears `selected` and gives no response. An `rca` of zero never selects.
- R9: A command index that is not legal in the current state, or any input while `cmdValid` is low, gives no response and leaves `cardState`, `rca` and `selected` unchanged.
- R10: Index 0 in any state except inactive moves the state to idle, clears `rca` and `selected`, and gives no response.
- R11: `respValid` is high for exactly the one cycle after an accepted command. While it is low, `respKind` and `respData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Decoded command present this cycle |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| cardState | output | 3 | 0 idle, 1 ready, 2 identification, 3 standby, 4 inactive |
| rca | output | 16 | Current relative card address |
| selected | output | 1 | Card selected for later addressed commands |
| respValid | output | 1 | Response request, one cycle |
| respKind | output | 2 | 0 none, 1 operating conditions, 2 card tag, 3 address |
| respData | output | 32 | Response payload |

## Verification
The bench aims at the double address assignment. A design that kept the first RCA would report 0x1234 where 0xBEEF is expected, and would still select on the old address. It also aims at the zero-voltage query, where a wrong design would leave idle. Other targets are a zero RCA followed by a select carrying zero, which a careless match would accept, and the inactive state, where a design that honoured index 0 would come back to idle. Illegal indices in every state and strobe-low cycles catch designs that let a command through without its state guard.

// File: rtl/sdio_id_pkg.sv
package sdio_id_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READY    = 3'd1,
    ST_IDENT    = 3'd2,
    ST_STANDBY  = 3'd3,
    ST_INACTIVE = 3'd4
  } cardState_e;

  typedef enum logic [1:0] {
    RK_NONE   = 2'd0,
    RK_OPCOND = 2'd1,
    RK_CID    = 2'd2,
    RK_ADDR   = 2'd3
  } respKind_e;

  // Control-to-datapath strobes, valid for one cycle
  typedef struct packed {
    logic      clearRca;
    logic      loadRca;
    logic      setSel;
    logic      clrSel;
    logic      respEn;
    respKind_e respKind;
  } idStrobe_t;

endpackage

// File: rtl/sdio_id_ctrl.sv
module sdio_id_ctrl
  import sdio_id_pkg::*;
#(
  parameter int                 IDX_W       = 6,
  parameter int                 OCR_W       = 24,
  parameter logic [OCR_W-1:0]   OCR_MASK    = 24'h3C0000,
  parameter int                 CMD_GO_IDLE = 0,
  parameter int                 CMD_ALL_CID = 2,
  parameter int                 CMD_SET_RCA = 3,
  parameter int                 CMD_OPCOND  = 5,
  parameter int                 CMD_SELECT  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [OCR_W-1:0] voltWin,
  input  logic             rcaMatch,
  output cardState_e       state,
  output idStrobe_t        strobe
);

  cardState_e nextState;
  logic [OCR_W-1:0] overlap;
  logic compatible;
  logic queryOnly;

  // Per-bit voltage overlap between host window and supported range
  for (genvar b = 0; b < OCR_W; b++) begin : g_overlap
    assign overlap[b] = voltWin[b] & OCR_MASK[b];
  end

  assign compatible = |overlap;
  assign queryOnly  = (voltWin == '0);

  logic isGoIdle, isAllCid, isSetRca, isOpcond, isSelect;
  assign isGoIdle = (cmdIndex == IDX_W'(CMD_GO_IDLE));
  assign isAllCid = (cmdIndex == IDX_W'(CMD_ALL_CID));
  assign isSetRca = (cmdIndex == IDX_W'(CMD_SET_RCA));
  assign isOpcond = (cmdIndex == IDX_W'(CMD_OPCOND));
  assign isSelect = (cmdIndex == IDX_W'(CMD_SELECT));

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (cmdValid && state != ST_INACTIVE) begin
      if (isGoIdle) begin
        nextState       = ST_IDLE;
        strobe.clearRca = 1'b1;
        strobe.clrSel   = 1'b1;
      end else if (isOpcond) begin
        if (state == ST_IDLE) begin
          strobe.respEn   = 1'b1;
          strobe.respKind = RK_OPCOND;
          if (!queryOnly) begin
            nextState = compatible ? ST_READY : ST_INACTIVE;
          end
        end
      end else if (isAllCid) begin
        if (state == ST_READY) begin
          nextState       = ST_IDENT;
          strobe.respEn   = 1'b1;
          strobe.respKind = RK_CID;
        end
      end else if (isSetRca) begin
        if (state == ST_READY || state == ST_IDENT || state == ST_STANDBY) begin
          nextState       = ST_STANDBY;
          strobe.loadRca  = 1'b1;
          strobe.clrSel   = 1'b1;
          strobe.respEn   = 1'b1;
          strobe.respKind = RK_ADDR;
        end
      end else if (isSelect) begin
        if (state == ST_STANDBY) begin
          if (rcaMatch) begin
            strobe.setSel   = 1'b1;
            strobe.respEn   = 1'b1;
            strobe.respKind = RK_ADDR;
          end else begin
            strobe.clrSel = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

endmodule

// File: rtl/sdio_id_dpath.sv
module sdio_id_dpath
  import sdio_id_pkg::*;
#(
  parameter int               ARG_W    = 32,
  parameter int               RCA_W    = 16,
  parameter int               OCR_W    = 24,
  parameter logic [OCR_W-1:0] OCR_MASK = 24'h3C0000,
  parameter logic [ARG_W-1:0] CARD_TAG = 32'h5D10_C0DE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RCA_W-1:0] argRca,
  input  idStrobe_t        strobe,
  output logic [RCA_W-1:0] rca,
  output logic             selected,
  output logic             rcaMatch,
  output logic             respValid,
  output respKind_e        respKind,
  output logic [ARG_W-1:0] respData
);

  localparam int PAD_W = ARG_W - OCR_W;
  localparam int LOW_W = ARG_W - RCA_W;

  logic [ARG_W-1:0] respNext;

  assign rcaMatch = (argRca == rca) && (rca != '0);

  always_comb begin
    respNext = '0;
    if (strobe.respEn) begin
      case (strobe.respKind)
        RK_OPCOND: respNext = {{PAD_W{1'b0}}, OCR_MASK};
        RK_CID:    respNext = CARD_TAG;
        RK_ADDR:   respNext = {argRca, {LOW_W{1'b0}}};
        default:   respNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rca       <= '0;
      selected  <= 1'b0;
      respValid <= 1'b0;
      respKind  <= RK_NONE;
      respData  <= '0;
    end else begin
      if (strobe.clearRca)     rca <= '0;
      else if (strobe.loadRca) rca <= argRca;
      if (strobe.clrSel)       selected <= 1'b0;
      else if (strobe.setSel)  selected <= 1'b1;
      respValid <= strobe.respEn;
      respKind  <= strobe.respEn ? strobe.respKind : RK_NONE;
      respData  <= respNext;
    end
  end

endmodule

// File: rtl/sdio_card_ident.sv
module sdio_card_ident
  import sdio_id_pkg::*;
#(
  parameter int               IDX_W    = 6,
  parameter int               ARG_W    = 32,
  parameter int               RCA_W    = 16,
  parameter int               OCR_W    = 24,
  parameter logic [OCR_W-1:0] OCR_MASK = 24'h3C0000,
  parameter logic [ARG_W-1:0] CARD_TAG = 32'h5D10_C0DE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [ARG_W-1:0] cmdArg,
  output logic [2:0]       cardState,
  output logic [RCA_W-1:0] rca,
  output logic             selected,
  output logic             respValid,
  output logic [1:0]       respKind,
  output logic [ARG_W-1:0] respData
);

  localparam int RCA_LSB = ARG_W - RCA_W;

  cardState_e state;
  idStrobe_t  strobe;
  respKind_e  kindQ;
  logic       rcaMatch;

  sdio_id_ctrl #(
    .IDX_W(IDX_W), .OCR_W(OCR_W), .OCR_MASK(OCR_MASK)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdIndex (cmdIndex),
    .voltWin  (cmdArg[OCR_W-1:0]),
    .rcaMatch (rcaMatch),
    .state    (state),
    .strobe   (strobe)
  );

  sdio_id_dpath #(
    .ARG_W(ARG_W), .RCA_W(RCA_W), .OCR_W(OCR_W),
    .OCR_MASK(OCR_MASK), .CARD_TAG(CARD_TAG)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .argRca    (cmdArg[ARG_W-1:RCA_LSB]),
    .strobe    (strobe),
    .rca       (rca),
    .selected  (selected),
    .rcaMatch  (rcaMatch),
    .respValid (respValid),
    .respKind  (kindQ),
    .respData  (respData)
  );

  assign cardState = state;
  assign respKind  = kindQ;

endmodule

// File: rtl/sdio_card_ident_chk.sv
module sdio_card_ident_chk #(
  parameter int RCA_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdValid,
  input logic [2:0]       cardState,
  input logic [RCA_W-1:0] rca,
  input logic             selected,
  input logic             respValid,
  input logic [1:0]       respKind
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cardState == 3'd0 && rca == '0 && !selected && !respValid));

  p_inactive_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    cardState == 3'd4 |=> (cardState == 3'd4 && !respValid));

  p_sel_needs_rca_r8: assert property (@(posedge clk) disable iff (rst)
    selected |-> (rca != '0 && cardState == 3'd3));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> ($stable(rca) && $stable(cardState) && $stable(selected) && !respValid));

  p_resp_after_cmd_r11: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(cmdValid));

  p_kind_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !respValid |-> respKind == 2'd0);

endmodule

bind sdio_card_ident sdio_card_ident_chk #(.RCA_W(RCA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cardState (cardState),
  .rca       (rca),
  .selected  (selected),
  .respValid (respValid),
  .respKind  (respKind)
);

// File: tb/sdio_card_ident_bench.sv
module sdio_card_ident_bench;

  localparam logic [23:0] MASK = 24'h3C0000;
  localparam logic [31:0] TAG  = 32'h5D10_C0DE;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmdValid;
  logic [5:0]  cmdIndex;
  logic [31:0] cmdArg;
  logic [2:0]  cardState;
  logic [15:0] rca;
  logic        selected;
  logic        respValid;
  logic [1:0]  respKind;
  logic [31:0] respData;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int          mState;
  logic [15:0] mRca;
  bit          mSel;
  bit          mRv;
  int          mKind;
  logic [31:0] mData;

  always #10 clk = ~clk;

  sdio_card_ident u_sdio_card_ident (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .cardState(cardState), .rca(rca), .selected(selected),
    .respValid(respValid), .respKind(respKind), .respData(respData)
  );

  task automatic model(input bit r, input bit v, input int idx, input logic [31:0] a);
    logic [15:0] ar = a[31:16];
    mRv = 0; mKind = 0; mData = 0;
    if (r) begin
      mState = 0; mRca = 0; mSel = 0;
      return;
    end
    if (!v || mState == 4) return;
    if (idx == 0) begin
      mState = 0; mRca = 0; mSel = 0;
    end else if (idx == 5 && mState == 0) begin
      mRv = 1; mKind = 1; mData = {8'h00, MASK};
      if (a[23:0] != 0) mState = ((a[23:0] & MASK) != 0) ? 1 : 4;
    end else if (idx == 2 && mState == 1) begin
      mState = 2; mRv = 1; mKind = 2; mData = TAG;
    end else if (idx == 3 && (mState == 1 || mState == 2 || mState == 3)) begin
      mState = 3; mRca = ar; mSel = 0; mRv = 1; mKind = 3; mData = {ar, 16'h0};
    end else if (idx == 7 && mState == 3) begin
      if (ar == mRca && mRca != 0) begin
        mSel = 1; mRv = 1; mKind = 3; mData = {ar, 16'h0};
      end else mSel = 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (cardState !== 3'(mState) || rca !== mRca || selected !== mSel ||
        respValid !== mRv || respKind !== 2'(mKind) || respData !== mData) begin
      errors++;
      $display("FAIL %s: got state=%0d rca=%h sel=%0d rv=%0d kind=%0d data=%h, expected state=%0d rca=%h sel=%0d rv=%0d kind=%0d data=%h",
               tag, cardState, rca, selected, respValid, respKind, respData,
               mState, mRca, mSel, mRv, mKind, mData);
    end
  endtask

  // Called at a negedge: drive, let one edge pass, compare at the next negedge
  task automatic step(input bit r, input bit v, input int idx, input logic [31:0] a,
                      input string tag);
    rst = r; cmdValid = v; cmdIndex = 6'(idx); cmdArg = a;
    @(posedge clk);
    model(r, v, idx, a);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; cmdValid = 0; cmdIndex = 0; cmdArg = 0;
    mState = 0; mRca = 0; mSel = 0; mRv = 0; mKind = 0; mData = 0;
    @(negedge clk);
    step(1, 0, 0, 0, "R1 reset");
    step(1, 0, 0, 0, "R1 reset hold");
    step(0, 1, 3, 32'h1111_0000, "R9 CMD3 in idle");
    step(0, 1, 7, 32'h1111_0000, "R9 CMD7 in idle");
    step(0, 1, 2, 0, "R9 CMD2 in idle");
    step(0, 1, 5, 32'h0, "R4 zero window query");
    step(0, 1, 5, 32'h0030_0000, "R2 compatible window");
    step(0, 0, 5, 32'h0030_0000, "R9 strobe low");
    step(0, 1, 5, 32'h0030_0000, "R9 CMD5 in ready");
    step(0, 1, 7, 32'h0, "R9 CMD7 in ready");
    step(0, 1, 2, 0, "R5 CMD2 to ident");
    step(0, 1, 3, 32'h1234_0000, "R6 first address");
    step(0, 1, 2, 0, "R9 CMD2 in standby");
    step(0, 1, 3, 32'hBEEF_0000, "R7 second address wins");
    step(0, 1, 7, 32'h1234_0000, "R8 stale address no select");
    step(0, 1, 7, 32'hBEEF_0000, "R8 select on current address");
    step(0, 0, 0, 0, "R11 response single cycle");
    step(0, 1, 7, 32'h0001_0000, "R8 other address deselects");
    step(0, 1, 7, 32'hBEEF_0000, "R8 reselect");
    step(0, 1, 3, 32'h5555_0000, "R7 reassign clears select");
    step(0, 1, 9, 32'h5555_0000, "R9 unknown index");
    step(0, 1, 0, 0, "R10 go idle");
    step(0, 1, 5, 32'h00FF_FF00, "R2 window overlap upper bits");
    step(0, 1, 3, 32'h0000_0000, "R6 zero address from ready");
    step(0, 1, 7, 32'h0000_0000, "R8 zero address never selects");
    step(0, 1, 0, 0, "R10 go idle from standby");
    step(0, 1, 5, 32'h0000_0001, "R3 incompatible window");
    step(0, 1, 0, 0, "R3 go idle ignored when inactive");
    step(0, 1, 5, 32'h0030_0000, "R3 CMD5 ignored when inactive");
    step(0, 1, 3, 32'h2222_0000, "R3 CMD3 ignored when inactive");
    step(1, 0, 0, 0, "R1 reset leaves inactive");
    step(0, 1, 5, 32'h0004_0000, "R2 single bit overlap");
    step(0, 1, 0, 0, "R10 go idle from ready");
    step(0, 1, 5, 32'h0020_0000, "R2 again");
    step(0, 1, 3, 32'hA5A5_0000, "R6 address straight from ready");
    step(0, 1, 7, 32'hA5A5_0000, "R8 select");
    step(1, 0, 0, 0, "R1 reset clears selection");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule